// File: doc/BRIEF.md
# Vectored Level Interrupt Controller

This block collects up to 96 level-sensitive interrupt inputs and turns them into one request line to a processor, together with a readable vector that names the source to service. The inputs are grouped into three banks of 32. Every input that is high at a clock edge sets a sticky pending bit. Each pending bit is then qualified by a per-source enable bit and a per-source mask bit. Any pending source that is enabled and not masked raises the request line.

Software reaches the block through a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. A service routine reads the vector register and handles the source it names. It then clears that source's pending bit by writing a one to it. It repeats this until the vector reads zero. The block also stores a protection-mode bit and a two-bit external-interrupt type field for other logic to use. Neither of these changes the interrupt path.

Source number n lives in bank n/32 at bit n%32. When several sources are active at once, the lowest-numbered one wins the vector.

Top module: `irqc_top`

## Requirements
- R1: After reset every pending, enable and mask bit, the protection bit and the type field are zero. `irq_o` is low and every register reads zero.
- R2: Source n is driven by `src_in[n]`. A high level at a clock edge sets pending bit n%32 of bank n/32. The bit stays set after the input falls. Bank b's pending bits read at address 0x10+4*b.
- R3: Writing to 0x10+4*b clears each pending bit of bank b whose write-data bit is one. Bits written as zero keep their value. An input that is still high at the clearing edge leaves its pending bit set.
- R4: The enable bits of bank b are read and written at 0x40+4*b. A source whose enable bit is zero affects neither `irq_o` nor the vector, but its pending bit is still set.
- R5: The mask bits of bank b are read and written at 0x50+4*b. A source whose mask bit is one affects neither `irq_o` nor the vector, but its pending bit is still set.
- R6: `irq_o` is high exactly when some source is pending, enabled and unmasked. It rises in the clock cycle after the edge that samples the input high, not earlier.
- R7: A read of address 0x00 returns four times the lowest-numbered pending, enabled, unmasked source number, or zero when there is none. Writes to 0x00 change nothing.
- R8: Address 0x08 stores a protection bit in data bit 0 and reads back zero in its other bits. Address 0x0C stores a two-bit type field in data bits 1:0 and reads back zero in its other bits.
- R9: Addresses that are not listed read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational from register state |
| src_in | input | 96 | Level interrupt inputs, bit n is source n |
| irq_o | output | 1 | Request line to the processor |

## Verification
A pending bit that is lost or falsely set shows up in the next pending-bank read, and it also changes `irq_o` and the vector within one cycle once the source is enabled. Errors in the gating logic or the priority scan make the vector name the wrong source, or give a nonzero vector while `irq_o` is low; the vector read after each enable, mask or clear write exposes these. A clear that reaches the wrong bank, or that wins over a still-high input, changes the pending word read back in the very next cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BANK_W    = 32;
    localparam int NUM_BANKS = 3;
    localparam int NUM_SRC   = BANK_W * NUM_BANKS;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int ADDR_W    = 8;
    localparam int NMI_W     = 2;

    localparam logic [ADDR_W-1:0] A_VECTOR = 8'h00;
    localparam logic [ADDR_W-1:0] A_PROT   = 8'h08;
    localparam logic [ADDR_W-1:0] A_TYPE   = 8'h0C;
    localparam logic [ADDR_W-1:0] A_PEND   = 8'h10;
    localparam logic [ADDR_W-1:0] A_ENA    = 8'h40;
    localparam logic [ADDR_W-1:0] A_MASK   = 8'h50;

    typedef logic [NUM_BANKS-1:0][BANK_W-1:0] bankvec_t;

    typedef struct packed {
        bankvec_t         pend;
        bankvec_t         ena;
        bankvec_t         mask;
        logic             prot;
        logic [NMI_W-1:0] ntype;
    } state_t;
endpackage

// File: rtl/irqc_bank.sv
// Next-state and qualification logic for one bank of sources.
module irqc_bank #(
    parameter int W = 32
) (
    input  logic [W-1:0] pend_q,
    input  logic [W-1:0] ena_q,
    input  logic [W-1:0] mask_q,
    input  logic [W-1:0] src,
    input  logic [W-1:0] wdata,
    input  logic         wr_pend,
    input  logic         wr_ena,
    input  logic         wr_mask,
    output logic [W-1:0] pend_d,
    output logic [W-1:0] ena_d,
    output logic [W-1:0] mask_d,
    output logic [W-1:0] live
);
    logic [W-1:0] clr;

    always_comb begin
        clr    = wr_pend ? wdata : '0;
        // a level still present wins over a write-one clear
        pend_d = (pend_q & ~clr) | src;
        ena_d  = wr_ena  ? wdata : ena_q;
        mask_d = wr_mask ? wdata : mask_q;
        live   = pend_q & ena_q & ~mask_q;
    end
endmodule

// File: rtl/irqc_pick.sv
// Lowest-index finder over a request vector.
module irqc_pick #(
    parameter int N     = 96,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [BANK_W-1:0]  bus_wdata,
    output logic [BANK_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq_o
);
    state_t st_q, st_d;

    bankvec_t pend_n, ena_n, mask_n, live;
    logic [NUM_BANKS-1:0] wr_pend, wr_ena, wr_mask;
    logic [NUM_SRC-1:0]   live_flat;
    logic                 win_found;
    logic [IDX_W-1:0]     win_idx;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign wr_pend[b] = bus_we && (bus_addr == A_PEND + ADDR_W'(4 * b));
        assign wr_ena[b]  = bus_we && (bus_addr == A_ENA  + ADDR_W'(4 * b));
        assign wr_mask[b] = bus_we && (bus_addr == A_MASK + ADDR_W'(4 * b));

        irqc_bank #(.W(BANK_W)) u_bank (
            .pend_q  (st_q.pend[b]),
            .ena_q   (st_q.ena[b]),
            .mask_q  (st_q.mask[b]),
            .src     (src_in[b*BANK_W +: BANK_W]),
            .wdata   (bus_wdata),
            .wr_pend (wr_pend[b]),
            .wr_ena  (wr_ena[b]),
            .wr_mask (wr_mask[b]),
            .pend_d  (pend_n[b]),
            .ena_d   (ena_n[b]),
            .mask_d  (mask_n[b]),
            .live    (live[b])
        );
    end

    assign live_flat = live;

    irqc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req   (live_flat),
        .found (win_found),
        .idx   (win_idx)
    );

    assign irq_o = win_found;

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_n;
        st_d.ena  = ena_n;
        st_d.mask = mask_n;
        if (bus_we && bus_addr == A_PROT) st_d.prot  = bus_wdata[0];
        if (bus_we && bus_addr == A_TYPE) st_d.ntype = bus_wdata[NMI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_VECTOR && win_found) bus_rdata = BANK_W'({win_idx, 2'b00});
        if (bus_addr == A_PROT) bus_rdata[0] = st_q.prot;
        if (bus_addr == A_TYPE) bus_rdata[NMI_W-1:0] = st_q.ntype;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == A_PEND + ADDR_W'(4 * b)) bus_rdata = st_q.pend[b];
            if (bus_addr == A_ENA  + ADDR_W'(4 * b)) bus_rdata = st_q.ena[b];
            if (bus_addr == A_MASK + ADDR_W'(4 * b)) bus_rdata = st_q.mask[b];
        end
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [BANK_W-1:0]  bus_wdata,
    input logic [BANK_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] src_in,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] ena_q,
    input logic [NUM_SRC-1:0] mask_q
);
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (src_in != '0) |=> ((pend_q & $past(src_in)) == $past(src_in))); // R2

    AST_PEND_ONLY_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R3

    AST_CLEAR_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_PEND && src_in[BANK_W-1:0] == '0)
        |=> ((pend_q[BANK_W-1:0] & $past(bus_wdata)) == '0)); // R3

    AST_ENA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(ena_q)); // R4

    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(mask_q)); // R5

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|(pend_q & ena_q & ~mask_q))); // R6

    AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_VECTOR && !irq_o) |-> (bus_rdata == '0)); // R7
endmodule

bind irqc_top irqc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_in    (src_in),
    .irq_o     (irq_o),
    .pend_q    (st_q.pend),
    .ena_q     (st_q.ena),
    .mask_q    (st_q.mask)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    import irqc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic               bus_we = 1'b0;
    logic [BANK_W-1:0]  bus_wdata = '0;
    logic [BANK_W-1:0]  bus_rdata;
    logic [NUM_SRC-1:0] src_in = '0;
    logic               irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // scoreboard queues: kind 0 = read data, kind 1 = irq line
    bit          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in), .irq_o(irq_o)
    );

    // monitor: compares the oldest expected item shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (kind_q.size() > 0) begin
                bit          k;
                logic [31:0] e, a;
                string       t;
                k = kind_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = k ? {31'd0, irq_o} : bus_rdata;
                n_checks++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
                end
            end
        end
    end

    task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = addr;
        kind_q.push_back(1'b0); exp_q.push_back(exp); tag_q.push_back(tag);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        bus_we = 1'b0;
        kind_q.push_back(1'b1); exp_q.push_back({31'd0, exp}); tag_q.push_back(tag);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
    endtask

    task automatic drive_src(input logic [NUM_SRC-1:0] v);
        @(negedge clk);
        bus_we = 1'b0; src_in = v;
    endtask

    task automatic drive_src_chk(input logic [NUM_SRC-1:0] v, input logic exp, input string tag);
        @(negedge clk);
        bus_we = 1'b0; src_in = v;
        kind_q.push_back(1'b1); exp_q.push_back({31'd0, exp}); tag_q.push_back(tag);
    endtask

    function automatic logic [NUM_SRC-1:0] one_src(input int n);
        logic [NUM_SRC-1:0] v;
        v = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, 32'h0, "R1 vector");
        rd(8'h10, 32'h0, "R1 pend0");
        rd(8'h18, 32'h0, "R1 pend2");
        rd(8'h44, 32'h0, "R1 ena1");
        rd(8'h50, 32'h0, "R1 mask0");
        rd(8'h08, 32'h0, "R1 prot");
        rd(8'h0C, 32'h0, "R1 type");
        chk_irq(1'b0, "R1 irq");

        // R2 sticky level capture, bank = n/32, bit = n%32
        drive_src(one_src(22)); drive_src('0);
        drive_src(one_src(70)); drive_src('0);
        rd(8'h10, 32'h0040_0000, "R2 src22 pend0");
        rd(8'h18, 32'h0000_0040, "R2 src70 pend2");
        chk_irq(1'b0, "R4 disabled irq");
        rd(8'h00, 32'h0, "R4 disabled vector");

        // R4 enable, R7 vector
        wr(8'h40, 32'h0040_0000);
        chk_irq(1'b1, "R6 irq after enable");
        rd(8'h40, 32'h0040_0000, "R4 ena0 readback");
        rd(8'h00, 32'd88, "R7 vector src22");
        wr(8'h48, 32'h0000_0040);
        rd(8'h00, 32'd88, "R7 lowest wins");
        wr(8'h10, 32'h0040_0000);
        rd(8'h10, 32'h0, "R3 clear src22");
        rd(8'h00, 32'd280, "R7 vector src70");

        // R5 mask
        wr(8'h58, 32'h0000_0040);
        chk_irq(1'b0, "R5 masked irq");
        rd(8'h00, 32'h0, "R5 masked vector");
        rd(8'h18, 32'h0000_0040, "R5 pend kept");
        wr(8'h58, 32'h0);
        chk_irq(1'b1, "R5 unmasked irq");

        // R3 level beats clear
        drive_src(one_src(70));
        wr(8'h18, 32'h0000_0040);
        rd(8'h18, 32'h0000_0040, "R3 clear while high");
        drive_src('0);
        wr(8'h18, 32'h0000_0040);
        rd(8'h18, 32'h0, "R3 clear after low");
        chk_irq(1'b0, "R6 irq low after clear");

        // R3 zero bits untouched
        drive_src({64'd0, 32'h0000_0024}); drive_src('0);
        wr(8'h10, 32'h0000_0020);
        rd(8'h10, 32'h0000_0004, "R3 partial clear");

        // R7 vector is read-only
        wr(8'h40, 32'h0040_0004);
        rd(8'h00, 32'd8, "R7 vector src2");
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'd8, "R7 vector write ignored");
        rd(8'h10, 32'h0000_0004, "R7 pend after vector write");

        // R8 protection and type fields
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h1, "R8 prot");
        wr(8'h0C, 32'h0000_00FF);
        rd(8'h0C, 32'h3, "R8 type");

        // R9 unmapped address
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0, "R9 unmapped read");
        rd(8'h40, 32'h0040_0004, "R9 ena0 unchanged");
        rd(8'h10, 32'h0000_0004, "R9 pend0 unchanged");

        // R6 one-cycle latency on source 33
        wr(8'h10, 32'h0000_0004);
        chk_irq(1'b0, "R6 idle");
        wr(8'h44, 32'h0000_0002);
        drive_src_chk(one_src(33), 1'b0, "R6 irq before edge");
        drive_src_chk('0, 1'b1, "R6 irq after edge");
        rd(8'h00, 32'd132, "R7 vector src33");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule